// File: doc/BRIEF.md
# Parallel Port Compatibility-Mode Receiver

This block is the peripheral end of a host-to-device byte download over a classic 8-bit parallel printer port. It runs in compatibility (Centronics) mode. The host puts a byte on the data lines, waits until BUSY is low, and pulses its active-low strobe. The receiver takes the byte and hands it to an on-chip consumer over a valid/ready stream. It then answers with a low acknowledge pulse.

All host control inputs pass through two-flop synchronizers into the local clock. A strobe counts only on its synchronized falling edge. The data bus is sampled one clock after that edge, once it has settled. BUSY stays high from the strobe until the acknowledge has finished, so a downstream consumer that holds off ready throttles the host directly.

The host's select line turns download mode on while it is low. While it is high, BUSY is held high and strobes are dropped. A low pulse on the host's init line starts a new session and clears the session byte counter.

Top module: `pport_rx`

## Requirements
- R1: After reset `busy_o` is 1, `ack_no` is 1, `byte_valid_o` is 0 and `session_count_o` is 0.
- R2: While `host_select_ni` is high (download mode off), `busy_o` is 1. Within 4 clocks of `host_select_ni` going low with no transfer in progress, `busy_o` is 0.
- R3: In download mode, a falling edge on `host_strobe_ni` makes `byte_o` present the value that `host_data_i` held during the strobe, with `byte_valid_o` high.
- R4: While `byte_valid_o` is 1 and `byte_ready_i` is 0, the next clock still has `byte_valid_o` at 1 and `byte_o` unchanged.
- R5: `busy_o` is 1 from the strobe detection through the whole acknowledge pulse. It is never 0 while `ack_no` is 0.
- R6: `ack_no` goes low only after the byte has been accepted downstream (never together with `byte_valid_o`). It stays low for exactly ACK_CYCLES clocks.
- R7: `session_count_o` rises by one for each byte accepted downstream (valid and ready both 1). It wraps modulo 2^CNT_W.
- R8: While the synchronized `host_init_ni` is low, `session_count_o` is cleared to 0, and it stays 0 after the pulse ends.
- R9: A strobe that arrives while download mode is off forwards no byte, produces no acknowledge and leaves the count unchanged.
- R10: Bytes come out on `byte_o` in the order the host strobed them, with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_data_i | input | DATA_W | Host data lines |
| host_strobe_ni | input | 1 | Host strobe, active low, asynchronous |
| host_select_ni | input | 1 | Host select, low enables download mode, asynchronous |
| host_init_ni | input | 1 | Host init, low pulse starts a session, asynchronous |
| busy_o | output | 1 | Busy to host, high holds the host off |
| ack_no | output | 1 | Acknowledge to host, active-low pulse |
| byte_o | output | DATA_W | Received byte toward the consumer |
| byte_valid_o | output | 1 | Byte is valid |
| byte_ready_i | input | 1 | Consumer accepts the byte |
| session_count_o | output | CNT_W | Bytes accepted since the last init pulse |

## Verification
The bench builds the block with ACK_CYCLES = 3 and CNT_W = 4. A short pulse keeps each acknowledge measurable in a few clocks. The 4-bit counter lets one session of 17 bytes reach the modulo wrap of the session count. Ready follows an irregular stall pattern in one phase, so held-valid stability and BUSY backpressure both come into play.

// File: rtl/pport_pkg.sv
package pport_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_OFFER  = 2'd2,
    ST_ACK    = 2'd3
  } rx_state_e;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int          WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/pport_counter.sv
module pport_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  assert_count_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clear_i) |=> count_o == $past(count_o) + 1'b1);
  assert_count_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> count_o == '0);
endmodule

// File: rtl/pport_fsm.sv
module pport_fsm
  import pport_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ACK_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_fall_i,
  input  logic              dl_mode_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic              ack_no,
  output logic              busy_o
);
  localparam int ACK_W = (ACK_CYCLES > 1) ? $clog2(ACK_CYCLES) : 1;
  localparam logic [ACK_W-1:0] ACK_LAST = ACK_W'(ACK_CYCLES - 1);

  rx_state_e        state_q, state_d;
  logic [ACK_W-1:0] ack_cnt_q;
  logic [DATA_W-1:0] byte_q;
  logic             busy_q, ack_nq;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (strobe_fall_i && dl_mode_i) state_d = ST_SAMPLE;
      ST_SAMPLE: state_d = ST_OFFER;
      ST_OFFER:  if (ready_i) state_d = ST_ACK;
      ST_ACK:    if (ack_cnt_q == ACK_LAST) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ack_cnt_q <= '0;
      byte_q    <= '0;
      busy_q    <= 1'b1;
      ack_nq    <= 1'b1;
    end else begin
      state_q <= state_d;
      if (state_q == ST_SAMPLE) byte_q <= data_i;  // bus settled one clock after edge
      if (state_q != ST_ACK)    ack_cnt_q <= '0;
      else                      ack_cnt_q <= ack_cnt_q + 1'b1;
      busy_q <= (state_d != ST_IDLE) || !dl_mode_i;
      ack_nq <= (state_d != ST_ACK);
    end
  end

  assign byte_o  = byte_q;
  assign valid_o = (state_q == ST_OFFER);
  assign ack_no  = ack_nq;
  assign busy_o  = busy_q;

  assert_hold_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(byte_o)));
  assert_busy_in_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_no |-> busy_o);
  assert_ack_after_handoff_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_no) |-> $past(valid_o && ready_i));
  assert_ack_no_overlap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && !ack_no));
endmodule

// File: rtl/pport_rx.sv
module pport_rx #(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 24,
  parameter int ACK_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] host_data_i,
  input  logic              host_strobe_ni,
  input  logic              host_select_ni,
  input  logic              host_init_ni,
  output logic              busy_o,
  output logic              ack_no,
  output logic [DATA_W-1:0] byte_o,
  output logic              byte_valid_o,
  input  logic              byte_ready_i,
  output logic [CNT_W-1:0]  session_count_o
);
  logic [2:0] ctl_sync;
  logic       strobe_s, select_s, init_s, strobe_prev_q, strobe_fall;

  pport_sync #(.WIDTH(3), .RST_VAL(3'b111)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({host_init_ni, host_select_ni, host_strobe_ni}),
    .sync_o  (ctl_sync)
  );
  assign {init_s, select_s, strobe_s} = ctl_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_prev_q <= 1'b1;
    else         strobe_prev_q <= strobe_s;
  end
  assign strobe_fall = strobe_prev_q && !strobe_s;

  pport_fsm #(.DATA_W(DATA_W), .ACK_CYCLES(ACK_CYCLES)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .strobe_fall_i (strobe_fall),
    .dl_mode_i     (!select_s),
    .data_i        (host_data_i),
    .byte_o        (byte_o),
    .valid_o       (byte_valid_o),
    .ready_i       (byte_ready_i),
    .ack_no        (ack_no),
    .busy_o        (busy_o)
  );

  pport_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!init_s),
    .inc_i   (byte_valid_o && byte_ready_i),
    .count_o (session_count_o)
  );

  assert_off_mode_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(select_s) |-> busy_o);
  assert_drop_off_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_fall && select_s && !byte_valid_o && ack_no) |=> (!byte_valid_o && ack_no));
endmodule

// File: tb/sim_pport_rx.sv
module sim_pport_rx;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 4;
  localparam int ACK_N  = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [DATA_W-1:0] host_data = '0;
  logic strobe_n = 1'b1, select_n = 1'b1, init_n = 1'b1, ready = 1'b1;
  logic busy, ack_n, valid;
  logic [DATA_W-1:0] byte_out;
  logic [CNT_W-1:0]  count;

  always #2 clk = ~clk;

  pport_rx #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ACK_CYCLES(ACK_N)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .host_data_i(host_data),
    .host_strobe_ni(strobe_n), .host_select_ni(select_n), .host_init_ni(init_n),
    .busy_o(busy), .ack_no(ack_n), .byte_o(byte_out), .byte_valid_o(valid),
    .byte_ready_i(ready), .session_count_o(count)
  );

  int checks = 0, fails = 0, valid_seen = 0, ack_pulses = 0;
  logic stall = 1'b0, done = 1'b0;
  logic [DATA_W-1:0] exp_q[$];

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ready pattern
  int cyc = 0;
  initial forever begin
    @(negedge clk);
    cyc++;
    ready = stall ? ((cyc % 3) == 2) : 1'b1;
  end

  // monitor: scoreboard, hold stability, ack pulse shape
  logic hold_prev = 1'b0;
  logic [DATA_W-1:0] hold_byte = '0;
  int ack_len = 0;
  logic busy_bad = 1'b0;
  initial forever begin
    @(negedge clk);
    if (rst_ni) begin
      if (hold_prev)
        check(valid && byte_out == hold_byte, "R4 held byte", int'(byte_out), int'(hold_byte));
      if (valid) valid_seen++;
      if (valid && ready) begin
        if (exp_q.size() == 0) check(1'b0, "R10 unexpected byte", int'(byte_out), 0);
        else begin
          logic [DATA_W-1:0] e;
          e = exp_q.pop_front();
          check(byte_out == e, "R3 R10 byte", int'(byte_out), int'(e));
        end
      end
      hold_prev = valid && !ready;
      hold_byte = byte_out;
      if (!ack_n) begin
        ack_len++;
        if (ack_len == 1) check(!valid, "R6 ack overlaps valid", int'(valid), 0);
        if (!busy) busy_bad = 1'b1;
      end else if (ack_len > 0) begin
        ack_pulses++;
        check(ack_len == ACK_N, "R6 ack length", ack_len, ACK_N);
        check(!busy_bad, "R5 busy during ack", int'(busy_bad), 0);
        ack_len = 0;
        busy_bad = 1'b0;
      end
    end
  end

  task automatic send(input logic [DATA_W-1:0] b);
    while (busy) @(negedge clk);
    host_data = b;
    @(negedge clk);
    strobe_n = 1'b0;
    exp_q.push_back(b);
    repeat (4) @(negedge clk);
    check(busy, "R5 busy after strobe", int'(busy), 1);
    while (ack_n) @(negedge clk);
    strobe_n = 1'b1;
    host_data = ~b;
    while (busy) @(negedge clk);
  endtask

  task automatic pulse_init();
    @(negedge clk);
    init_n = 1'b0;
    repeat (4) @(negedge clk);
    init_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (1000000) @(negedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy && ack_n && !valid && count == 0, "R1 reset state",
          int'({busy, ack_n, valid}), 3'b110);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    check(busy, "R2 busy with mode off", int'(busy), 1);
    check(count == 0, "R1 count after reset", int'(count), 0);
    select_n = 1'b0;
    repeat (4) @(negedge clk);
    check(!busy, "R2 busy released in mode", int'(busy), 0);

    pulse_init();
    check(count == 0, "R8 count after init", int'(count), 0);
    for (int i = 0; i < 5; i++) send(8'h10 + 8'(i * 37));
    check(count == 5, "R7 count session one", int'(count), 5);

    stall = 1'b1;
    send(8'h00); send(8'hFF); send(8'hA5); send(8'h5A); send(8'h01); send(8'h80);
    check(count == 11, "R7 count with stalls", int'(count), 11);
    stall = 1'b0;
    for (int i = 0; i < 6; i++) send(8'(8'hC3 ^ i));
    check(count == 1, "R7 count wraps", int'(count), 1);

    // strobe with download mode off
    select_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy, "R2 busy when mode dropped", int'(busy), 1);
    begin
      int v0, a0;
      v0 = valid_seen; a0 = ack_pulses;
      host_data = 8'hEE;
      @(negedge clk);
      strobe_n = 1'b0;
      repeat (10) @(negedge clk);
      check(ack_n, "R9 no ack when off", int'(ack_n), 1);
      strobe_n = 1'b1;
      repeat (6) @(negedge clk);
      select_n = 1'b0;
      repeat (6) @(negedge clk);
      check(valid_seen == v0, "R9 no byte forwarded", valid_seen - v0, 0);
      check(ack_pulses == a0, "R9 no ack pulse", ack_pulses - a0, 0);
      check(count == 1, "R9 count unchanged", int'(count), 1);
    end

    send(8'h3C);
    check(count == 2, "R7 count after resume", int'(count), 2);
    pulse_init();
    check(count == 0, "R8 init clears count", int'(count), 0);
    send(8'h77);
    check(count == 1, "R7 new session count", int'(count), 1);
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R10 all bytes delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule